// File: doc/BRIEF.md
# Watermark-Flagged FIFO Serial Transmitter

This block is the transmit half of a synchronous serial port. Software-side logic writes bytes one per cycle into a 16-entry queue. A serializer takes the oldest byte whenever it becomes free and sends it least significant bit first on a single data line. Each bit lasts one period of a bit clock that the block divides down from the system clock and also drives out.

A data-request output tells the feeding logic when to top the queue up. It is high while the queue fill count is at or below a 4-bit threshold and low while the count is above it. Two framing styles are selectable. Interval framing raises a frame-sync output for the bit period that carries bit 0 of each word and leaves one idle low bit period after every word. Continuous framing sends words back to back with no frame-sync at all. A synchronous enable clears the whole path when it is deasserted.

Top module: `wm_serial_tx`

## Requirements
- R1: Accepted bytes leave the serial line whole and in the order they were written; the queue holds up to 16 bytes.
- R2: While enabled, `req_o` is 1 whenever the queue fill count is less than or equal to `wmark_i`.
- R3: While enabled, `req_o` is 0 whenever the queue fill count is greater than `wmark_i`.
- R4: Each word is sent bit 0 first and bit 7 last, one bit per period of `sclk_o`. A period is `CLK_DIV` system cycles, with `sclk_o` low in the first half and high in the second half. `sdata_o` changes only where `sclk_o` falls, so a receiver samples it on the rising edge.
- R5: With `mode_i` = 1 (interval), `fsync_o` is high for exactly the bit period carrying bit 0 of every word. Every word is followed by one bit period with `sdata_o` and `fsync_o` both 0.
- R6: With `mode_i` = 0 (continuous), `fsync_o` stays 0, and the bit 0 of a queued word occupies the bit period right after the previous word's bit 7.
- R7: A write while the queue holds 16 bytes is discarded and sets `ovf_o`, which stays 1 until the enable is removed.
- R8: If the queue is empty when a word boundary is reached, `sdata_o` keeps its last value and no frame-sync is produced.
- R9: While `en_i` is 0, the queue and serializer are cleared and writes are ignored. `sdata_o`, `fsync_o`, `sclk_o`, `req_o` and `ovf_o` are all 0 from the following cycle onward.
- R10: After reset, `sdata_o`, `fsync_o`, `sclk_o`, `req_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmit enable; 0 flushes the path |
| mode_i | input | 1 | Framing: 1 = interval with sync, 0 = continuous |
| wmark_i | input | 4 | Request threshold on the queue fill count |
| wr_en_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Byte to queue |
| sclk_o | output | 1 | Generated bit clock |
| sdata_o | output | 1 | Serial data, LSB first |
| fsync_o | output | 1 | Frame-sync for bit 0 in interval mode |
| req_o | output | 1 | Data request from threshold compare |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
The bench drives the request flag across its threshold in both directions around a pop that lands in the same cycle as a write. An off-by-one compare would flip `req_o` one entry early or late. It overfills the queue so that exactly one slot is freed during the burst. A design that accepted a write when full, or lost one, would deliver the wrong byte count or order. In continuous mode it checks that words follow each other with no gap and carry no sync, and in interval mode that every word has its sync and its idle slot; a misplaced gap would shift every later bit. After a flush, it checks that a byte left over from before the flush, or written while disabled, never reaches the line.

// File: rtl/wm_serial_tx_pkg.sv
package wm_serial_tx_pkg;
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_DATA = 2'd1,
    SH_GAP  = 2'd2
  } sh_state_e;

  localparam logic MODE_CONT = 1'b0;
  localparam logic MODE_INTV = 1'b1;
endpackage

// File: rtl/wst_bitclk.sv
module wst_bitclk #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  output logic tick,
  output logic bclk
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(CLK_DIV / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, bclk_d;

  always_comb begin
    if (!en)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
    bclk_d = en && (cnt_d >= HALF);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign tick = en && (cnt_q == LAST);
  assign bclk = bclk_q;

  // R4: a bit boundary always starts the low half of the bit clock
  a_r4_low_after_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> !bclk);
endmodule

// File: rtl/wst_fifo.sv
module wst_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic              full,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] LVL_MAX  = LW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]     level_q, level_d;
  logic              do_push, do_pop;

  assign full    = (level_q == LVL_MAX);
  assign empty   = (level_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_d = level_q + 1'b1;
        2'b01:   level_d = level_q - 1'b1;
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign level = level_q;

  // R1: the fill count never exceeds the queue depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    level_q <= LVL_MAX);
  // R7: a write into a full queue with no pop leaves it full, not wrapped
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && push && !pop && !flush) |=> (level_q == LVL_MAX));
endmodule

// File: rtl/wst_shifter.sv
module wst_shifter
  import wm_serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic              tick,
  input  logic              mode,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              q_pop,
  output logic              sdata,
  output logic              fsync
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

  sh_state_e         st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              sd_q, sd_d, fs_q, fs_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    sr_d  = sr_q;
    sd_d  = sd_q;
    fs_d  = fs_q;
    q_pop = 1'b0;
    if (!en) begin
      st_d  = SH_IDLE;
      idx_d = '0;
      sr_d  = '0;
      sd_d  = 1'b0;
      fs_d  = 1'b0;
    end else if (tick) begin
      fs_d = 1'b0;
      if (st_q == SH_DATA && idx_q != IDX_LAST) begin
        idx_d = idx_q + 1'b1;
        sd_d  = sr_q[0];
        sr_d  = sr_q >> 1;
      end else if (st_q == SH_DATA && mode == MODE_INTV) begin
        st_d = SH_GAP;
        sd_d = 1'b0;
      end else if (!q_empty) begin
        q_pop = 1'b1;
        st_d  = SH_DATA;
        idx_d = '0;
        sd_d  = q_head[0];
        sr_d  = {1'b0, q_head[DATA_W-1:1]};
        fs_d  = (mode == MODE_INTV);
      end else begin
        st_d = SH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SH_IDLE;
      idx_q <= '0;
      sr_q  <= '0;
      sd_q  <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sr_q  <= sr_d;
      sd_q  <= sd_d;
      fs_q  <= fs_d;
    end
  end

  assign sdata = sd_q;
  assign fsync = fs_q;

  // R4: the line moves only on a bit boundary
  a_r4_hold_within_bit: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !tick) |=> $stable(sd_q));
  // R5: sync only accompanies the first bit of a word
  a_r5_sync_on_bit0: assert property (@(posedge clk) disable iff (!rst_ni)
    fs_q |-> (st_q == SH_DATA && idx_q == '0));
  // R5: sync covers the whole bit period
  a_r5_sync_full_bit: assert property (@(posedge clk) disable iff (!rst_ni)
    (fs_q && en && !tick) |=> fs_q);
  // R9: disabling returns the line and sync to low
  a_r9_flush_line: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (!sd_q && !fs_q));
endmodule

// File: rtl/wm_serial_tx.sv
module wm_serial_tx #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int WM_W    = 4,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [WM_W-1:0]   wmark_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              fsync_o,
  output logic              req_o,
  output logic              ovf_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tick, q_pop, q_full, q_empty;
  logic [DATA_W-1:0] q_head;
  logic [LW-1:0]     q_level;
  logic              ovf_q, ovf_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wst_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .en     (en_i),
    .tick   (tick),
    .bclk   (sclk_o)
  );

  wst_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .flush  (!en_i),
    .push   (wr_en_i && en_i),
    .wdata  (wr_data_i),
    .pop    (q_pop),
    .rdata  (q_head),
    .level  (q_level),
    .full   (q_full),
    .empty  (q_empty)
  );

  wst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .en      (en_i),
    .tick    (tick),
    .mode    (mode_i),
    .q_empty (q_empty),
    .q_head  (q_head),
    .q_pop   (q_pop),
    .sdata   (sdata_o),
    .fsync   (fsync_o)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (!en_i)                  ovf_d = 1'b0;
    else if (wr_en_i && q_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovf_q <= 1'b0;
    else            ovf_q <= ovf_d;
  end

  assign ovf_o = ovf_q;
  assign req_o = en_i && (int'(q_level) <= int'(wmark_i));

  // R7: the overflow flag is sticky while enabled
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovf_o && en_i) |=> ovf_o);
  // R9: a disabled cycle leaves an empty queue and a clear flag behind
  a_r9_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> (q_level == '0 && !ovf_o));
endmodule

// File: tb/wm_serial_tx_tb_top.sv
module wm_serial_tx_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n, en_i, mode_i, wr_en_i;
  logic [3:0] wmark_i;
  logic [7:0] wr_data_i;
  logic       sclk_o, sdata_o, fsync_o, req_o, ovf_o;

  always #2 clk = ~clk;

  wm_serial_tx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .wmark_i(wmark_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .fsync_o(fsync_o),
    .req_o(req_o), .ovf_o(ovf_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // ---------------- monitor: a serial receiver ----------------
  bit         in_word = 0, gap_pend = 0, prev_b = 0, werr = 0;
  int         bitn = 0, cyc = 0, last_rise = 0;
  logic [7:0] acc;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n || !en_i) begin
      in_word = 0; gap_pend = 0; prev_b = 0;
    end else begin
      if (sclk_o && !prev_b) begin
        if (gap_pend) begin
          chk(!sdata_o && !fsync_o, "R5 idle slot", {sdata_o, fsync_o}, 0);
          gap_pend = 0;
        end else begin
          if (!in_word && ((mode_i && fsync_o) || (!mode_i && exp_q.size() > 0))) begin
            in_word = 1; bitn = 0; werr = 0;
          end
          if (in_word) begin
            if (bitn > 0 && (fsync_o || (cyc - last_rise) != DIV)) werr = 1;
            if (!mode_i && fsync_o) werr = 1;
            acc[bitn] = sdata_o;
            bitn++;
            if (bitn == 8) begin
              in_word = 0;
              if (exp_q.size() == 0) chk(0, "R1 unexpected word", acc, 0);
              else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(acc == e, "R1 R4 word", acc, e);
              end
              if (mode_i) begin
                chk(!werr, "R5 sync/bit timing", werr, 0);
                gap_pend = 1;
              end else chk(!werr, "R6 no sync, gapless", werr, 0);
            end
          end
        end
        last_rise = cyc;
      end
      prev_b = sclk_o;
    end
  end

  // ---------------- driver ----------------
  task automatic start_burst();
    @(posedge sclk_o);
    @(negedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] d, input bit accepted);
    wr_en_i = 1'b1; wr_data_i = d;
    if (accepted) exp_q.push_back(d);
    @(posedge clk);
    #1;
  endtask

  task automatic end_burst();
    wr_en_i = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(posedge clk);
    #1 en_i = v;
  endtask

  task automatic wait_drain();
    wait (exp_q.size() == 0 && !in_word && !gap_pend);
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic hold_check(input logic b, input string rq);
    int bad = 0;
    repeat (24) begin
      @(negedge clk);
      if (sdata_o !== b || fsync_o !== 1'b0) bad++;
    end
    chk(bad == 0, rq, bad, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; en_i = 0; mode_i = 1; wr_en_i = 0; wr_data_i = 0; wmark_i = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R10 reset state
    chk(sdata_o === 0, "R10 sdata", sdata_o, 0);
    chk(fsync_o === 0, "R10 fsync", fsync_o, 0);
    chk(sclk_o === 0, "R10 sclk", sclk_o, 0);
    chk(req_o === 0, "R10 req", req_o, 0);
    chk(ovf_o === 0, "R10 ovf", ovf_o, 0);

    // interval mode, threshold 0, empty queue -> request
    set_en(1);
    #1 chk(req_o === 1, "R2 empty at wmark 0", req_o, 1);

    // R2 R3 threshold crossing, interval framing R5
    wmark_i = 4'd2;
    start_burst();
    write_byte(8'hA5, 1);
    write_byte(8'h3C, 1);            // lands with the first pop: level 1
    write_byte(8'hF0, 1);            // level 2
    chk(req_o === 1, "R2 level equals wmark", req_o, 1);
    write_byte(8'h01, 1);            // level 3
    chk(req_o === 0, "R3 level above wmark", req_o, 0);
    write_byte(8'h80, 1);            // level 4
    chk(req_o === 0, "R3 level above wmark", req_o, 0);
    end_burst();
    wait_drain();
    chk(req_o === 1, "R2 request after drain", req_o, 1);
    hold_check(1'b0, "R8 interval empty holds idle");

    // continuous framing R6, hold last bit R8
    set_en(0);
    mode_i = 0;
    set_en(1);
    start_burst();
    write_byte(8'h5A, 1);
    write_byte(8'hC3, 1);
    write_byte(8'h0F, 1);
    write_byte(8'h81, 1);
    end_burst();
    wait_drain();
    hold_check(1'b1, "R8 continuous holds last bit");

    // overflow R7: 20 writes, one pop during the burst -> 17 accepted
    start_burst();
    for (int i = 0; i < 20; i++) write_byte(8'(i * 29 + 7), i < 17);
    end_burst();
    chk(ovf_o === 1, "R7 overflow set", ovf_o, 1);
    wait_drain();
    chk(ovf_o === 1, "R7 overflow sticky", ovf_o, 1);

    // flush R9
    start_burst();
    for (int i = 0; i < 8; i++) write_byte(8'(8'h40 + i), 1);
    end_burst();
    repeat (50) @(posedge clk);
    #1 en_i = 0;
    exp_q.delete();
    repeat (2) @(posedge clk);
    #1;
    chk(sdata_o === 0, "R9 sdata low", sdata_o, 0);
    chk(fsync_o === 0, "R9 fsync low", fsync_o, 0);
    chk(sclk_o === 0, "R9 sclk stopped", sclk_o, 0);
    chk(req_o === 0, "R9 req low", req_o, 0);
    chk(ovf_o === 0, "R9 ovf cleared", ovf_o, 0);
    wr_en_i = 1; wr_data_i = 8'hEE;   // ignored while disabled
    @(posedge clk);
    #1 wr_en_i = 0;
    set_en(1);
    #1 chk(req_o === 1, "R9 queue empty after flush", req_o, 1);
    start_burst();
    write_byte(8'h3C, 1);
    end_burst();
    wait_drain();
    chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
    summary();
  end
endmodule